// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-facing register file of a four-channel DMA controller of the classic kind. Software reaches it through an 8-bit I/O port block of 32 offsets. For each channel it holds a 16-bit base and current address, a 16-bit base and current count, an 8-bit page register for address bits 23:16, an 8-bit high-page register for bits 31:24, and a 6-bit mode field. The programmed values go out on flat buses to a transfer engine. The engine pulses one step line per channel for every unit it moves.

Every 16-bit register sits behind a single 8-bit port. A single byte pointer, shared by all channels, decides whether an access lands on the low byte or the high byte. Any access to an address or count port flips the pointer. A write to a dedicated port returns it to the low byte.

Writing a channel's high-page register arms full 32-bit addressing for that channel. Once armed, the current address carries out of bit 15 into the page bits. If it is not armed, the low 16 bits wrap and the upper bits stay as they are. Writing the page register disarms the channel again, so the high-page write has to come last in a setup sequence.

Top module: `dmac_regs`

## Requirements
- R1: After reset every register, every output and the byte pointer are zero, so the first byte access lands on the low byte and no channel is armed for 32-bit addressing.
- R2: A write to offset 2n (n = 0..3) stores the data byte into both the base and current address of channel n. It goes to bits 7:0 when the pointer is low and to bits 15:8 when it is high.
- R3: A write to offset 2n+1 stores the data byte into both the base and current count of channel n, with the same byte selection as R2.
- R4: Every read or write of offsets 0..7 flips the byte pointer, and the pointer is shared by all channels. No other access changes it, except the clear described in R5.
- R5: Any write to offset 9 forces the byte pointer low, whatever the data byte is.
- R6: A write to offset 8 stores data bits 7:2 as the 6-bit mode of the channel named by data bits 1:0, and leaves the other channels' modes unchanged.
- R7: A write to offset 16+n sets address bits 23:16 of channel n and disarms 32-bit addressing. A write to offset 24+n sets bits 31:24 and arms it.
- R8: A read of offset 2n returns the selected byte of channel n's current address bits 15:0. A read of 2n+1 returns the selected byte of its current count. Offsets 16+n and 24+n return the page and high-page registers. Every other offset, and every cycle without a read, returns 0.
- R9: A step pulse on channel n decrements its current count, wrapping from 0 to 0xFFFF. It also increments the current address: over all 32 bits when the channel is armed, and within bits 15:0 only when it is not.
- R10: A write to channel n's address, count, page or high-page port in the same cycle as its step pulse cancels that step. A mode write does not cancel a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Port write strobe, one cycle per access |
| io_rd | input | 1 | Port read strobe, one cycle per access |
| io_addr | input | 5 | Port offset within the block |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational during io_rd |
| eng_step | input | 4 | One step pulse per channel from the transfer engine |
| ch_addr | output | 128 | Current 32-bit address per channel, channel n at bits 32n+31:32n |
| ch_count | output | 64 | Current count per channel |
| ch_base_addr | output | 64 | Base address bits 15:0 per channel |
| ch_base_count | output | 64 | Base count per channel |
| ch_mode | output | 24 | 6-bit mode per channel |
| ch_wide | output | 4 | 32-bit addressing armed, per channel |

## Verification
The assertions take for granted that the bus carries at most one access per cycle, that io_wr and io_rd are never high together, and that all inputs stay idle while reset is held. Read strobes are taken to have no side effect other than the pointer flip. The bench drives exactly one of write, read or idle in each cycle and keeps every input at zero during reset. Its random phase draws offsets over the whole 32-entry map, so unmapped offsets and reads of write-only ports also occur, and it overlaps step pulses with writes to the same channel and to other channels.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int AW  = 5;
    localparam int DW  = 8;
    localparam int RW  = 2 * DW;
    localparam int MW  = DW - 2;
    localparam int CHW = 2;

    localparam logic [AW-1:0] OFS_MODE   = 5'h08;
    localparam logic [AW-1:0] OFS_CLRPTR = 5'h09;
    localparam logic [AW-1:0] OFS_PAGE   = 5'h10;
    localparam logic [AW-1:0] OFS_HIPG   = 5'h18;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ADDR,
        ACC_CNT,
        ACC_MODE,
        ACC_CLR,
        ACC_PAGE,
        ACC_HIPG
    } acc_e;

    typedef struct packed {
        acc_e            kind;
        logic [CHW-1:0]  ch;
        logic            wr;
        logic            rd;
        logic [DW-1:0]   data;
    } acc_t;

    // Classify one bus access. Writes win over reads.
    function automatic acc_t decode_access(
        input logic          wr,
        input logic          rd,
        input logic [AW-1:0] a,
        input logic [DW-1:0] d,
        input int            nch
    );
        acc_t r;
        r.kind = ACC_NONE;
        r.ch   = '0;
        r.wr   = wr;
        r.rd   = rd & ~wr;
        r.data = d;
        if (wr || rd) begin
            if (a < AW'(2 * nch)) begin
                r.kind = a[0] ? ACC_CNT : ACC_ADDR;
                r.ch   = a[CHW:1];
            end else if (wr && a == OFS_MODE) begin
                r.kind = ACC_MODE;
                r.ch   = d[CHW-1:0];
            end else if (wr && a == OFS_CLRPTR) begin
                r.kind = ACC_CLR;
            end else if (a[AW-1:AW-2] == OFS_PAGE[AW-1:AW-2] && int'(a[2:0]) < nch) begin
                r.kind = ACC_PAGE;
                r.ch   = a[CHW-1:0];
            end else if (a[AW-1:AW-2] == OFS_HIPG[AW-1:AW-2] && int'(a[2:0]) < nch) begin
                r.kind = ACC_HIPG;
                r.ch   = a[CHW-1:0];
            end
        end
        return r;
    endfunction

    function automatic logic is_byte_port(input acc_e k);
        return (k == ACC_ADDR) || (k == ACC_CNT);
    endfunction

endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    input  logic clear,
    output logic ptr_hi
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr_hi <= 1'b0;
        end else if (toggle) begin
            ptr_hi <= ~ptr_hi;
        end
    end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int BW = DW,
    parameter int CW = RW,
    parameter int MODEW = MW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  acc_e             kind,
    input  logic [BW-1:0]    wdata,
    input  logic             ptr_hi,
    input  logic             step,
    output logic [2*CW-1:0]  cur_addr,
    output logic [CW-1:0]    cur_cnt,
    output logic [CW-1:0]    base_addr,
    output logic [CW-1:0]    base_cnt,
    output logic [BW-1:0]    page,
    output logic [BW-1:0]    hipg,
    output logic [MODEW-1:0] mode,
    output logic             wide
);
    localparam int HI  = BW;
    localparam int PGL = CW;
    localparam int HPL = CW + BW;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            base_addr <= '0;
            base_cnt  <= '0;
            page      <= '0;
            hipg      <= '0;
            mode      <= '0;
            wide      <= 1'b0;
        end else begin
            if (hit && kind == ACC_ADDR) begin
                if (ptr_hi) begin
                    base_addr[HI +: BW] <= wdata;
                    cur_addr[HI +: BW]  <= wdata;
                end else begin
                    base_addr[0 +: BW]  <= wdata;
                    cur_addr[0 +: BW]   <= wdata;
                end
            end else if (hit && kind == ACC_CNT) begin
                if (ptr_hi) begin
                    base_cnt[HI +: BW]  <= wdata;
                    cur_cnt[HI +: BW]   <= wdata;
                end else begin
                    base_cnt[0 +: BW]   <= wdata;
                    cur_cnt[0 +: BW]    <= wdata;
                end
            end else if (hit && kind == ACC_PAGE) begin
                page                <= wdata;
                cur_addr[PGL +: BW] <= wdata;
                wide                <= 1'b0;
            end else if (hit && kind == ACC_HIPG) begin
                hipg                <= wdata;
                cur_addr[HPL +: BW] <= wdata;
                wide                <= 1'b1;
            end else if (step) begin
                cur_cnt <= cur_cnt - CW'(1);
                if (wide) begin
                    cur_addr <= cur_addr + (2*CW)'(1);
                end else begin
                    cur_addr[CW-1:0] <= cur_addr[CW-1:0] + CW'(1);
                end
            end
            if (hit && kind == ACC_MODE) begin
                mode <= wdata[BW-1:BW-MODEW];
            end
        end
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [AW-1:0]      io_addr,
    input  logic [DW-1:0]      io_wdata,
    output logic [DW-1:0]      io_rdata,
    input  logic [NCH-1:0]     eng_step,
    output logic [NCH*2*RW-1:0] ch_addr,
    output logic [NCH*RW-1:0]  ch_count,
    output logic [NCH*RW-1:0]  ch_base_addr,
    output logic [NCH*RW-1:0]  ch_base_count,
    output logic [NCH*MW-1:0]  ch_mode,
    output logic [NCH-1:0]     ch_wide
);
    localparam int AFW = 2 * RW;

    acc_t acc;
    logic ptr_hi;

    logic [AFW-1:0] cur_a  [NCH];
    logic [RW-1:0]  cnt_a  [NCH];
    logic [DW-1:0]  page_a [NCH];
    logic [DW-1:0]  hipg_a [NCH];

    always_comb acc = decode_access(io_wr, io_rd, io_addr, io_wdata, NCH);

    dmac_byteptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .toggle (is_byte_port(acc.kind)),
        .clear  (acc.kind == ACC_CLR),
        .ptr_hi (ptr_hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = acc.wr && (acc.ch == CHW'(g));

        dmac_chan #(.BW(DW), .CW(RW), .MODEW(MW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .hit       (hit),
            .kind      (acc.kind),
            .wdata     (acc.data),
            .ptr_hi    (ptr_hi),
            .step      (eng_step[g]),
            .cur_addr  (cur_a[g]),
            .cur_cnt   (cnt_a[g]),
            .base_addr (ch_base_addr[g*RW +: RW]),
            .base_cnt  (ch_base_count[g*RW +: RW]),
            .page      (page_a[g]),
            .hipg      (hipg_a[g]),
            .mode      (ch_mode[g*MW +: MW]),
            .wide      (ch_wide[g])
        );

        assign ch_addr[g*AFW +: AFW] = cur_a[g];
        assign ch_count[g*RW +: RW]  = cnt_a[g];
    end

    always_comb begin
        io_rdata = '0;
        if (acc.rd) begin
            case (acc.kind)
                ACC_ADDR: io_rdata = ptr_hi ? cur_a[acc.ch][DW +: DW] : cur_a[acc.ch][0 +: DW];
                ACC_CNT:  io_rdata = ptr_hi ? cnt_a[acc.ch][DW +: DW] : cnt_a[acc.ch][0 +: DW];
                ACC_PAGE: io_rdata = page_a[acc.ch];
                ACC_HIPG: io_rdata = hipg_a[acc.ch];
                default:  io_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk
    import dmac_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               io_wr,
    input logic               io_rd,
    input logic [AW-1:0]      io_addr,
    input logic [DW-1:0]      io_wdata,
    input logic [NCH-1:0]     eng_step,
    input logic [NCH*RW-1:0]  ch_count,
    input logic [NCH*MW-1:0]  ch_mode,
    input logic [NCH-1:0]     ch_wide,
    input logic               ptr_hi
);
    localparam logic [AW-1:0] LIM = AW'(2 * NCH);

    logic port_acc;
    assign port_acc = (io_wr || io_rd) && (io_addr < LIM);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_wide == '0 && ch_count == '0 && !ptr_hi));

    // R4
    ptr_flip_chk: assert property (@(posedge clk) disable iff (rst)
        port_acc |=> (ptr_hi != $past(ptr_hi)));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!port_acc && !(io_wr && io_addr == OFS_CLRPTR)) |=> $stable(ptr_hi));

    // R5
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFS_CLRPTR) |=> !ptr_hi);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic touch;
        assign touch = io_wr && ((io_addr < LIM && io_addr[AW-1:1] == (AW-1)'(c))
                              || io_addr == OFS_PAGE + AW'(c)
                              || io_addr == OFS_HIPG + AW'(c));

        // R7
        arm_chk: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_addr == OFS_HIPG + AW'(c)) |=> ch_wide[c]);

        // R7
        disarm_chk: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_addr == OFS_PAGE + AW'(c)) |=> !ch_wide[c]);

        // R6
        mode_store_chk: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_addr == OFS_MODE && io_wdata[CHW-1:0] == CHW'(c))
            |=> (ch_mode[c*MW +: MW] == $past(io_wdata[DW-1:DW-MW])));

        // R9
        step_dec_chk: assert property (@(posedge clk) disable iff (rst)
            (eng_step[c] && !touch)
            |=> (ch_count[c*RW +: RW] == $past(ch_count[c*RW +: RW]) - RW'(1)));

        // R10
        step_cancel_chk: assert property (@(posedge clk) disable iff (rst)
            (eng_step[c] && io_wr && io_addr == AW'(2*c+1) && !ptr_hi)
            |=> (ch_count[c*RW +: DW] == $past(io_wdata)));
    end
endmodule

bind dmac_regs dmac_regs_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .eng_step (eng_step),
    .ch_count (ch_count),
    .ch_mode  (ch_mode),
    .ch_wide  (ch_wide),
    .ptr_hi   (ptr_hi)
);

// File: tb/dmac_regs_bench.sv
`timescale 1ns/1ps
module dmac_regs_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         io_wr = 1'b0, io_rd = 1'b0;
    logic [4:0]   io_addr = '0;
    logic [7:0]   io_wdata = '0;
    logic [7:0]   io_rdata;
    logic [3:0]   eng_step = '0;
    logic [127:0] ch_addr;
    logic [63:0]  ch_count, ch_base_addr, ch_base_count;
    logic [23:0]  ch_mode;
    logic [3:0]   ch_wide;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_cur [4];
    logic [15:0] m_cnt [4], m_badr [4], m_bcnt [4];
    logic [7:0]  m_pg [4], m_hp [4];
    logic [5:0]  m_mode [4];
    bit          m_wide [4];
    bit          m_ptr;

    always #10 clk = ~clk;

    dmac_regs u_dmac_regs (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_step(eng_step),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_base_addr(ch_base_addr),
        .ch_base_count(ch_base_count), .ch_mode(ch_mode), .ch_wide(ch_wide)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_cur[c] = 0; m_cnt[c] = 0; m_badr[c] = 0; m_bcnt[c] = 0;
            m_pg[c] = 0; m_hp[c] = 0; m_mode[c] = 0; m_wide[c] = 0;
        end
        m_ptr = 0;
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        logic [15:0] v;
        if (a < 8) begin
            v = (a % 2 == 1) ? m_cnt[a/2] : m_cur[a/2][15:0];
            return m_ptr ? v[15:8] : v[7:0];
        end
        if (a >= 16 && a < 20) return m_pg[a-16];
        if (a >= 24 && a < 28) return m_hp[a-24];
        return 8'h00;
    endfunction

    task automatic model_step(input bit wr, input bit rd, input int a, input logic [7:0] d,
                              input logic [3:0] st);
        bit touched [4];
        for (int c = 0; c < 4; c++)
            touched[c] = wr && ((a < 8 && a/2 == c) || a == 16 + c || a == 24 + c);
        if (wr) begin
            if (a < 8) begin
                if (a % 2 == 0) begin
                    if (m_ptr) begin m_badr[a/2][15:8] = d; m_cur[a/2][15:8] = d; end
                    else       begin m_badr[a/2][7:0]  = d; m_cur[a/2][7:0]  = d; end
                end else begin
                    if (m_ptr) begin m_bcnt[a/2][15:8] = d; m_cnt[a/2][15:8] = d; end
                    else       begin m_bcnt[a/2][7:0]  = d; m_cnt[a/2][7:0]  = d; end
                end
                m_ptr = !m_ptr;
            end else if (a == 8) begin
                m_mode[d % 4] = d[7:2];
            end else if (a == 9) begin
                m_ptr = 0;
            end else if (a >= 16 && a < 20) begin
                m_pg[a-16] = d; m_cur[a-16][23:16] = d; m_wide[a-16] = 0;
            end else if (a >= 24 && a < 28) begin
                m_hp[a-24] = d; m_cur[a-24][31:24] = d; m_wide[a-24] = 1;
            end
        end else if (rd && a < 8) begin
            m_ptr = !m_ptr;
        end
        for (int c = 0; c < 4; c++) begin
            if (st[c] && !touched[c]) begin
                m_cnt[c] = m_cnt[c] - 16'd1;
                if (m_wide[c]) m_cur[c] = m_cur[c] + 32'd1;
                else m_cur[c][15:0] = m_cur[c][15:0] + 16'd1;
            end
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < 4; c++) begin
            chk("R9 current address", ch_addr[c*32 +: 32], m_cur[c]);
            chk("R3 current count", {16'h0, ch_count[c*16 +: 16]}, {16'h0, m_cnt[c]});
            chk("R2 base address", {16'h0, ch_base_addr[c*16 +: 16]}, {16'h0, m_badr[c]});
            chk("R3 base count", {16'h0, ch_base_count[c*16 +: 16]}, {16'h0, m_bcnt[c]});
            chk("R6 mode", {26'h0, ch_mode[c*6 +: 6]}, {26'h0, m_mode[c]});
            chk("R7 wide", {31'h0, ch_wide[c]}, {31'h0, m_wide[c]});
        end
    endtask

    // one bus cycle; inputs change just after a falling edge
    task automatic cycle(input bit wr, input bit rd, input int a, input logic [7:0] d,
                         input logic [3:0] st, input string tag);
        io_wr = wr; io_rd = rd; io_addr = a[4:0]; io_wdata = d; eng_step = st;
        #2;
        if (rd && !wr) chk(tag, {24'h0, io_rdata}, {24'h0, exp_rd(a)});
        @(posedge clk);
        model_step(wr, rd, a, d, st);
        @(negedge clk);
        io_wr = 0; io_rd = 0; eng_step = '0;
        compare_all();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cycle(1, 0, a, d, 4'h0, "");
    endtask

    task automatic rd(input int a, input string tag);
        cycle(0, 1, a, 8'h00, 4'h0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        compare_all();
        chk("R1 wide after reset", {28'h0, ch_wide}, 32'h0);
        rd(16, "R1 page after reset");
        wr(0, 8'h11);                       // R1: pointer starts low
        chk("R1 first byte low", {16'h0, ch_base_addr[15:0]}, 32'h0000_0011);

        // R2, R3: program channel 0 after a clear
        wr(9, 8'hA5);
        wr(0, 8'h34); wr(0, 8'h12);
        wr(1, 8'hFF); wr(1, 8'h00);
        chk("R2 ch0 address", {16'h0, ch_base_addr[15:0]}, 32'h0000_1234);
        chk("R3 ch0 count", {16'h0, ch_count[15:0]}, 32'h0000_00FF);
        rd(1, "R8 count low byte");
        rd(1, "R8 count high byte");
        rd(0, "R8 address low byte");
        rd(0, "R8 address high byte");

        // R4: pointer shared across channels
        wr(7, 8'hCD);                       // ch3 count low
        wr(4, 8'hEE);                       // ch2 address high byte
        chk("R4 ch3 count low", {16'h0, ch_count[63:48]}, 32'h0000_00CD);
        chk("R4 ch2 high byte", {16'h0, ch_base_addr[47:32]}, 32'h0000_EE00);
        rd(6, "R4 read flips pointer");
        wr(2, 8'h99);
        chk("R4 after read flip", {16'h0, ch_base_addr[31:16]}, 32'h0000_9900);

        // R5: clear with arbitrary data, then low byte again
        wr(9, 8'hFF);
        rd(6, "R5 low after clear");
        wr(9, 8'h00);
        wr(9, 8'h3C);
        rd(1, "R5 repeated clear keeps low");

        // R6: mode writes
        wr(8, 8'hA6);
        wr(8, 8'h1F);
        chk("R6 ch2 mode", {26'h0, ch_mode[17:12]}, 32'h29);
        chk("R6 ch3 mode", {26'h0, ch_mode[23:18]}, 32'h07);

        // R9: unarmed channel 0 wraps in 16 bits
        wr(9, 8'h00);
        wr(0, 8'hFF); wr(0, 8'hFF);
        wr(16, 8'h11);
        wr(1, 8'h01); wr(1, 8'h00);
        cycle(0, 0, 31, 8'h00, 4'b0001, "");
        cycle(0, 0, 31, 8'h00, 4'b0001, "");
        chk("R9 unarmed wrap", ch_addr[31:0], 32'h0011_0001);
        chk("R9 count wrap", {16'h0, ch_count[15:0]}, 32'h0000_FFFF);

        // R7, R9: armed channel 2 carries into page bits
        wr(4, 8'hFF); wr(4, 8'hFF);
        wr(18, 8'h56); wr(26, 8'h78);
        chk("R7 armed", {31'h0, ch_wide[2]}, 32'h1);
        cycle(0, 0, 31, 8'h00, 4'b0100, "");
        chk("R9 armed carry", ch_addr[95:64], 32'h7857_0000);
        rd(18, "R8 page read");
        rd(26, "R8 high page read");
        wr(18, 8'h56);
        chk("R7 page write disarms", {31'h0, ch_wide[2]}, 32'h0);

        // R10: write to same channel cancels step, mode write does not
        wr(9, 8'h00);
        wr(3, 8'h40); wr(3, 8'h00);
        cycle(1, 0, 3, 8'h22, 4'b0010, "");
        chk("R10 step cancelled", {16'h0, ch_count[31:16]}, 32'h0000_0022);
        cycle(1, 0, 8, 8'h05, 4'b0010, "");
        chk("R10 mode write keeps step", {16'h0, ch_count[31:16]}, 32'h0000_0021);
        cycle(1, 0, 0, 8'h00, 4'b0010, "");
        chk("R10 other-channel write keeps step", {16'h0, ch_count[31:16]}, 32'h0000_0020);
        rd(20, "R8 unmapped offset");
        rd(8, "R8 mode port reads zero");

        // random phase: all of R2..R10 against the model
        for (int i = 0; i < 600; i++) begin
            int k = $urandom_range(0, 2);
            cycle(k == 1, k == 2, $urandom_range(0, 31), 8'($urandom),
                  4'($urandom), "R8 random read");
        end
        finish_run();
    end
endmodule